// File: doc/BRIEF.md
# Four-Lane Bit-Interleaving Serial Multiplexer

This block merges four slow one-bit serial lanes into a single serial output that runs four times faster, by time-division interleaving. Everything runs on one fast clock. A capture strobe, high for one fast cycle in every four, copies one bit from each lane into a holding register. A free-running two-bit slot counter then walks through the held bits, one per fast cycle, so that every lane gets exactly one output slot in each strobe period.

The slot counter is not realigned to the first capture. The lane that goes out first therefore depends on the counter phase at the moment the holding register first fills. The block reports that lane on `leadLane` and marks every slot that carries lane 0 with `frameStart`, so a downstream splitter can recover the lane order. When the `ALIGN_ON_START` parameter is set, the output stays silent after the first capture until the counter comes round to lane 0. In that case the first emitted slot always carries lane 0.

Top module: `lane_interleaver`

## Requirements
- R1: While `rst` is high at a clock edge, the slot counter goes to 00 and the held bits, `serOut`, `frameStart` and `leadLane` all go to 0.
- R2: At a clock edge where `capStrobe` is high, the held bits take the value of `laneIn`, with bit i of `laneIn` belonging to lane i.
- R3: The slot counter advances by one at every clock edge in the cyclic order 0, 1, 2, 3, 0. Once output is enabled, `serOut` after an edge equals the held bit of the lane that the counter named just before that edge.
- R4: With `capStrobe` high once every four cycles at any fixed phase, every captured bit appears on `serOut` exactly once, in the four slots that follow its capture.
- R5: `serOut` and `frameStart` stay 0 until the edge that follows the first capture after reset.
- R6: `frameStart` is high exactly in the output slots that carry lane 0. It is never high in two consecutive cycles.
- R7: `leadLane` gives the lane of the first emitted slot after reset and holds that value until the next reset. If the first capture happens at the k-th edge after reset (counting from 0), the value is (k+1) mod 4.
- R8: With `ALIGN_ON_START` = 1, output after the first capture is held at 0 until the counter reaches lane 0. The first emitted slot therefore carries lane 0, with `frameStart` high, and `leadLane` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, one output slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| capStrobe | input | 1 | One-cycle capture enable, once per four cycles |
| laneIn | input | 4 | Lane bits, bit i is lane i |
| serOut | output | 1 | Interleaved serial output |
| frameStart | output | 1 | High in the slot carrying lane 0 |
| leadLane | output | 2 | Lane emitted first since reset |

## Verification
The bench builds two copies of the block side by side from the same stimulus. One copy uses `ALIGN_ON_START` = 0, which exposes all four possible lead lanes as the capture phase is swept. The other uses `ALIGN_ON_START` = 1, which brings the withheld-output window and the forced lane-0 start within reach. Both copies use the default of four lanes. Runs restart under reset at each strobe phase with random, walking-one and alternating lane data, so a bit emitted in the wrong slot, repeated or dropped shows up in the bit-by-bit comparison and in the per-run count of ones.

// File: rtl/lane_interleaver_pkg.sv
package lane_interleaver_pkg;

  // Strobes from the control section to the datapath, valid for one cycle
  typedef struct packed {
    logic capture;    // load lane bits into the holding register
    logic emit;       // drive a held bit onto the serial output this slot
    logic firstEmit;  // first emitted slot since reset
    logic frameSlot;  // current slot carries lane 0
  } ctrlStrobes_t;

endpackage

// File: rtl/lane_interleaver_ctrl.sv
module lane_interleaver_ctrl
  import lane_interleaver_pkg::*;
#(
  parameter int LANES = 4,
  parameter bit ALIGN_ON_START = 1'b0,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capStrobe,
  output ctrlStrobes_t     strb,
  output logic [SEL_W-1:0] slot
);

  localparam logic [SEL_W-1:0] LAST_SLOT = SEL_W'(LANES - 1);

  logic [SEL_W-1:0] selCnt;
  logic             started;   // holding register has valid data
  logic             aligned;   // output has been enabled at least once
  logic             emitGate;

  always_ff @(posedge clk) begin
    if (rst) begin
      selCnt  <= '0;
      started <= 1'b0;
      aligned <= 1'b0;
    end else begin
      selCnt <= (selCnt == LAST_SLOT) ? '0 : selCnt + 1'b1;
      if (capStrobe) started <= 1'b1;
      if (emitGate)  aligned <= 1'b1;
    end
  end

  generate
    if (ALIGN_ON_START) begin : g_align
      // withhold output until the counter reaches lane 0 once
      assign emitGate = started && (aligned || (selCnt == '0));
    end else begin : g_free
      assign emitGate = started;
    end
  endgenerate

  always_comb begin
    strb.capture   = capStrobe;
    strb.emit      = emitGate;
    strb.firstEmit = emitGate && !aligned;
    strb.frameSlot = (selCnt == '0);
  end

  assign slot = selCnt;

endmodule

// File: rtl/lane_interleaver_dp.sv
module lane_interleaver_dp
  import lane_interleaver_pkg::*;
#(
  parameter int LANES = 4,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] laneIn,
  input  ctrlStrobes_t     strb,
  input  logic [SEL_W-1:0] slot,
  output logic             serOut,
  output logic             frameStart,
  output logic [SEL_W-1:0] leadLane
);

  logic [LANES-1:0] holdReg;
  logic [LANES-1:0] hit;
  logic             pick;

  always_ff @(posedge clk) begin
    if (rst)               holdReg <= '0;
    else if (strb.capture) holdReg <= laneIn;
  end

  // AND-OR slot selector, one term per lane
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_pick
      assign hit[g] = holdReg[g] & (slot == SEL_W'(g));
    end
  endgenerate

  assign pick = |hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      serOut     <= 1'b0;
      frameStart <= 1'b0;
      leadLane   <= '0;
    end else begin
      serOut     <= strb.emit & pick;
      frameStart <= strb.emit & strb.frameSlot;
      if (strb.firstEmit) leadLane <= slot;
    end
  end

endmodule

// File: rtl/lane_interleaver.sv
module lane_interleaver
  import lane_interleaver_pkg::*;
#(
  parameter int LANES = 4,
  parameter bit ALIGN_ON_START = 1'b0,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capStrobe,
  input  logic [LANES-1:0] laneIn,
  output logic             serOut,
  output logic             frameStart,
  output logic [SEL_W-1:0] leadLane
);

  ctrlStrobes_t     strb;
  logic [SEL_W-1:0] slotSel;

  lane_interleaver_ctrl #(
    .LANES(LANES),
    .ALIGN_ON_START(ALIGN_ON_START)
  ) u_ctrl (
    .clk(clk),
    .rst(rst),
    .capStrobe(capStrobe),
    .strb(strb),
    .slot(slotSel)
  );

  lane_interleaver_dp #(
    .LANES(LANES)
  ) u_dp (
    .clk(clk),
    .rst(rst),
    .laneIn(laneIn),
    .strb(strb),
    .slot(slotSel),
    .serOut(serOut),
    .frameStart(frameStart),
    .leadLane(leadLane)
  );

endmodule

// File: rtl/lane_interleaver_chk.sv
module lane_interleaver_chk #(
  parameter int LANES = 4,
  parameter bit ALIGN_ON_START = 1'b0,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             capStrobe,
  input logic             serOut,
  input logic             frameStart,
  input logic [SEL_W-1:0] leadLane,
  input logic [SEL_W-1:0] slotSel
);

  logic capSeen;
  logic frameSeen;

  always_ff @(posedge clk) begin
    if (rst) begin
      capSeen   <= 1'b0;
      frameSeen <= 1'b0;
    end else begin
      if (capStrobe)  capSeen   <= 1'b1;
      if (frameStart) frameSeen <= 1'b1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!serOut && !frameStart && (leadLane == '0) && (slotSel == '0)));

  // R3
  slot_order_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (slotSel == (($past(slotSel) == SEL_W'(LANES - 1)) ? '0
                          : SEL_W'($past(slotSel) + 1'b1))));

  // R5
  quiet_before_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !capSeen |=> (!serOut && !frameStart));

  // R6
  frame_slot_chk: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> ($past(slotSel) == '0));

  // R6
  frame_gap_chk: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> !frameStart);

  // R7
  lead_hold_chk: assert property (@(posedge clk) disable iff (rst)
    frameSeen |-> $stable(leadLane));

  generate
    if (ALIGN_ON_START) begin : g_align_chk
      // R8
      align_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frameSeen |-> (frameStart || !serOut));
    end
  endgenerate

endmodule

bind lane_interleaver lane_interleaver_chk #(
  .LANES(LANES),
  .ALIGN_ON_START(ALIGN_ON_START)
) chk_i (
  .clk(clk),
  .rst(rst),
  .capStrobe(capStrobe),
  .serOut(serOut),
  .frameStart(frameStart),
  .leadLane(leadLane),
  .slotSel(slotSel)
);

// File: tb/lane_interleaver_test.sv
module lane_interleaver_test;

  localparam time CLK_P = 20ns;
  localparam int  RUN_LEN = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       capStrobe = 1'b0;
  logic [3:0] laneIn = 4'b0;
  logic       serOut, frameStart;
  logic [1:0] leadLane;
  logic       serOutAl, frameStartAl;
  logic [1:0] leadLaneAl;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  lane_interleaver #(.LANES(4), .ALIGN_ON_START(1'b0)) uut (
    .clk(clk), .rst(rst), .capStrobe(capStrobe), .laneIn(laneIn),
    .serOut(serOut), .frameStart(frameStart), .leadLane(leadLane));

  lane_interleaver #(.LANES(4), .ALIGN_ON_START(1'b1)) uutAl (
    .clk(clk), .rst(rst), .capStrobe(capStrobe), .laneIn(laneIn),
    .serOut(serOutAl), .frameStart(frameStartAl), .leadLane(leadLaneAl));

  typedef struct {
    bit    ser;
    bit    fs;
    string tag;
  } exp_t;

  exp_t qPlain[$];
  exp_t qAl[$];

  // Expected-behaviour state for each instance (0 = free start, 1 = aligned start)
  int     mSel[2];
  bit [3:0] mHold[2];
  bit     mStarted[2];
  bit     mAligned[2];
  int     mLead[2];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic exp_t step(input int k, input bit align, input bit rstNow,
                                input bit strobe, input bit [3:0] lanes);
    exp_t e;
    bit   emit;
    if (rstNow) begin
      mSel[k] = 0; mHold[k] = '0; mStarted[k] = 0; mAligned[k] = 0; mLead[k] = 0;
      e = '{ser: 1'b0, fs: 1'b0, tag: "R1"};
      return e;
    end
    emit = mStarted[k] && (!align || mAligned[k] || mSel[k] == 0);
    if (emit) begin
      e.ser = mHold[k][mSel[k]];
      e.fs  = (mSel[k] == 0);
      e.tag = (align && !mAligned[k]) ? "R8" : "R2,R3";
      if (!mAligned[k]) mLead[k] = mSel[k];
      mAligned[k] = 1;
    end else begin
      e.ser = 1'b0;
      e.fs  = 1'b0;
      e.tag = mStarted[k] ? "R8" : "R5";
    end
    if (strobe) begin
      mHold[k]    = lanes;
      mStarted[k] = 1;
    end
    mSel[k] = (mSel[k] + 1) % 4;
    return e;
  endfunction

  // Driver side of the scoreboard: expected items per edge
  always @(posedge clk) begin
    qPlain.push_back(step(0, 1'b0, rst, capStrobe, laneIn));
    qAl.push_back(step(1, 1'b1, rst, capStrobe, laneIn));
  end

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (!done && qPlain.size() > 0) begin
      e = qPlain.pop_front();
      chk(serOut == e.ser, e.tag, serOut, e.ser);
      chk(frameStart == e.fs, "R6", frameStart, e.fs);
      chk(leadLane == 2'(mLead[0]), "R7", leadLane, mLead[0]);
    end
    if (!done && qAl.size() > 0) begin
      e = qAl.pop_front();
      chk(serOutAl == e.ser, {e.tag, " align"}, serOutAl, e.ser);
      chk(frameStartAl == e.fs, "R6 align", frameStartAl, e.fs);
      chk(leadLaneAl == 2'(mLead[1]), "R8 lead", leadLaneAl, mLead[1]);
    end
  end

  bit [7:0] lfsr = 8'hA5;

  task automatic run(input int offset, input int pat);
    int onesIn = 0;
    int onesOut = 0;
    int nCaps = 0;
    // reset for three cycles
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rst = 1'b1; capStrobe = 1'b0; laneIn = 4'hF;
    end
    @(negedge clk);
    chk(serOut == 1'b0 && frameStart == 1'b0 && leadLane == 2'd0, "R1 reset", serOut, 0);
    for (int cyc = 0; cyc < RUN_LEN + 8; cyc++) begin
      if (cyc > 0) @(negedge clk);
      // outputs now reflect edge cyc-1
      if (cyc - 1 >= offset + 1 && cyc - 1 <= offset + 4 * nCaps && nCaps > 0 &&
          cyc - 1 <= offset + 4 * ((RUN_LEN - offset + 3) / 4))
        onesOut += serOut;
      rst = 1'b0;
      capStrobe = (cyc < RUN_LEN) && (cyc % 4 == offset);
      if (capStrobe) begin
        case (pat)
          0: begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            laneIn = lfsr[3:0];
          end
          1: laneIn = 4'b0001 << ((cyc / 4) % 4);
          default: laneIn = ((cyc / 4) % 2 == 0) ? 4'b1010 : 4'b0101;
        endcase
        onesIn += $countones(laneIn);
        nCaps++;
      end else begin
        laneIn = ~laneIn;  // values off the strobe must not be captured
      end
    end
    @(negedge clk);
    chk(onesOut == onesIn, "R4 ones count", onesOut, onesIn);
    chk(leadLane == 2'((offset + 1) % 4), "R7 lead lane", leadLane, (offset + 1) % 4);
    chk(leadLaneAl == 2'd0, "R8 aligned lead", leadLaneAl, 0);
  endtask

  initial begin
    for (int o = 0; o < 4; o++)
      for (int p = 0; p < 3; p++)
        run(o, p);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog R3 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule